// File: doc/BRIEF.md
# Banked GPIO with Per-Pin Mode Nibbles

This block drives sixteen general-purpose pins. The pins are split unevenly over four register groups. Each group has one data word and one mode word, and both are reached through a small word-addressed register bus with a single-cycle write and a combinational read. Inside a group, every pin has one data bit at its position relative to the group's first pin. It also has a 4-bit mode nibble at four times that relative position.

The mode nibble puts a pin in plain input, plain output, or one of three alternate functions. Each alternate function is legal only on a fixed set of pins. When a mode write names a code that is not legal for a pin, that pin keeps its previous mode and a sticky error output is raised. Legal nibbles in the same write still take effect. Pad inputs pass through a two-stage synchronizer before they can be read back. While a pin drives its pad, the data read returns that pin's output latch.

Top module: `nibble_gpio_bank`

## Requirements
- R1: After a synchronous active-low reset, every pin is in mode 0x0, every output latch is 0, `pad_oe` is all zero and `cfg_err` is 0.
- R2: Pins 0-1 form group 0, pins 2-5 group 1, pins 6-9 group 2 and pins 10-15 group 3. A write to address g (0-3) loads the output latch of pin base+i from `bus_wdata[i]`, where base is 0, 2, 6 or 10. Bits beyond the group's pin count are ignored.
- R3: A write to address 4+g loads the mode of pin base+i from `bus_wdata[4i+3:4i]`. A read of that address returns the current nibbles in the same positions, with zeros above them. Reads are combinational.
- R4: In mode 0x8 a pin has `pad_oe` high and `pad_out` equal to its output latch.
- R5: Codes 0x0 and 0x8 are legal on every pin. Code 0x2 is legal only on pins 4 and 5. Code 0x9 is legal only on pins 0-3. Code 0xA is legal only on pins 0 and 1. Every other code is illegal.
- R6: An illegal nibble leaves that pin's mode unchanged. Legal nibbles for other pins in the same write are still applied.
- R7: `cfg_err` goes high in the cycle after any rejected nibble and stays high until reset.
- R8: A data read returns, for each pin, its synchronized pad level when `pad_oe` is low and its output latch when `pad_oe` is high.
- R9: A change on `pad_in` shows in a data read after exactly two rising clock edges, not after one.
- R10: In modes 0x9 and 0xA a pin drives `pad_oe` high with `pad_out` taken from `periph_out`. In mode 0x2, and in every mode other than 0x8, 0x9 and 0xA, `pad_oe` is low and `pad_out` follows the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 3 | Word address: 0-3 data groups, 4-7 mode groups |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pad_in | input | 16 | Asynchronous pad input levels |
| periph_out | input | 16 | Output values from alternate-function peripherals |
| pad_out | output | 16 | Pad output values |
| pad_oe | output | 16 | Pad output enables |
| cfg_err | output | 1 | Sticky flag for a rejected mode nibble |

## Verification
A write lands on the rising edge where `bus_wr` is sampled. The new latch, mode, `pad_oe`, `pad_out` and `cfg_err` are therefore checked half a clock after that edge. A read is combinational, so the bench sets the address on a falling edge and samples a moment later. For pad input, the bench changes `pad_in` on a falling edge and reads once after the first rising edge, expecting the old level, and again after the second, expecting the new one. In the random phase, `pad_in` is held for three edges before any read that depends on it.

// File: rtl/gpb_pkg.sv
// Shared constants and pin-geometry helpers for the banked GPIO.
// Assumes a fixed uneven grouping of sixteen pins into four groups.
package gpb_pkg;
    localparam int NPIN   = 16;
    localparam int NGRP   = 4;
    localparam int MODE_W = 4;
    localparam int WORD_W = 32;
    localparam int GRP_W  = $clog2(NGRP);
    localparam int ADDR_W = GRP_W + 1;

    localparam logic [MODE_W-1:0] MD_IN   = 4'h0;
    localparam logic [MODE_W-1:0] MD_UIN  = 4'h2;
    localparam logic [MODE_W-1:0] MD_OUT  = 4'h8;
    localparam logic [MODE_W-1:0] MD_ALTB = 4'h9;
    localparam logic [MODE_W-1:0] MD_ALTC = 4'hA;

    // Group that owns a pin
    function automatic int grp_of(input int p);
        if (p < 2)       return 0;
        else if (p < 6)  return 1;
        else if (p < 10) return 2;
        else             return 3;
    endfunction

    // First pin of a group
    function automatic int grp_base(input int g);
        case (g)
            0:       return 0;
            1:       return 2;
            2:       return 6;
            default: return 10;
        endcase
    endfunction

    // Position of a pin inside its group
    function automatic int rel_of(input int p);
        return p - grp_base(grp_of(p));
    endfunction

    // Whether a mode code may be applied to a pin
    function automatic logic mode_ok(input int p, input logic [MODE_W-1:0] m);
        case (m)
            MD_IN, MD_OUT: return 1'b1;
            MD_UIN:        return (p == 4) || (p == 5);
            MD_ALTB:       return p <= 3;
            MD_ALTC:       return p <= 1;
            default:       return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/gpb_sync.sv
// Multi-stage synchronizer for asynchronous pad levels.
// Assumes the inputs are quasi-static compared with the clock; each bit is independent.
module gpb_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift pad levels through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

    generate
        if (STAGES == 2) begin : g_chk2
            // R9
            sync_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (rst_n && $past(rst_n) && $past(rst_n, 2)) |-> (q == $past(d, 2)));
        end
    endgenerate
endmodule

// File: rtl/gpb_pin.sv
// One GPIO pin: output latch, mode nibble with legality filter, pad drive and readback select.
// Assumes the top level has already decoded the address and sliced the data bit and nibble.
module gpb_pin
    import gpb_pkg::*;
#(
    parameter int PIN = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dat_we,
    input  logic              dat_bit,
    input  logic              cfg_we,
    input  logic [MODE_W-1:0] cfg_nib,
    input  logic              sync_lvl,
    input  logic              periph_bit,
    output logic              pad_out,
    output logic              pad_oe,
    output logic              rd_bit,
    output logic [MODE_W-1:0] mode_q,
    output logic              rej
);
    logic lat_q;
    logic accept;

    assign accept = cfg_we && mode_ok(PIN, cfg_nib);
    assign rej    = cfg_we && !accept;

    // Output latch loads on a data write
    always_ff @(posedge clk) begin
        if (!rst_n)      lat_q <= 1'b0;
        else if (dat_we) lat_q <= dat_bit;
    end

    // Mode nibble loads only on a legal code
    always_ff @(posedge clk) begin
        if (!rst_n)      mode_q <= MD_IN;
        else if (accept) mode_q <= cfg_nib;
    end

    // Pad drive decided by mode
    always_comb begin
        case (mode_q)
            MD_OUT: begin
                pad_oe  = 1'b1;
                pad_out = lat_q;
            end
            MD_ALTB, MD_ALTC: begin
                pad_oe  = 1'b1;
                pad_out = periph_bit;
            end
            default: begin
                pad_oe  = 1'b0;
                pad_out = lat_q;
            end
        endcase
    end

    // Readback: pad level when not driving, latch when driving
    assign rd_bit = pad_oe ? lat_q : sync_lvl;

    // R5
    mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_ok(PIN, mode_q));
    // R6
    rej_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rej |=> $stable(mode_q));
endmodule

// File: rtl/nibble_gpio_bank.sv
// Top of the banked GPIO: bus decode, per-pin instances, synchronizer, read mux, sticky error.
// Assumes one bus access per cycle; reads are combinational and writes land on the clock edge.
module nibble_gpio_bank
    import gpb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [NPIN-1:0]   pad_in,
    input  logic [NPIN-1:0]   periph_out,
    output logic [NPIN-1:0]   pad_out,
    output logic [NPIN-1:0]   pad_oe,
    output logic              cfg_err
);
    logic [NPIN-1:0]   lvl_s;
    logic [NPIN-1:0]   rd_v;
    logic [NPIN-1:0]   rej_v;
    logic [MODE_W-1:0] mode_v [NPIN];
    logic              err_q;

    gpb_sync #(.W(NPIN), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (lvl_s)
    );

    generate
        for (genvar p = 0; p < NPIN; p++) begin : g_pin
            localparam int GRP = grp_of(p);
            localparam int REL = rel_of(p);
            logic dat_we;
            logic cfg_we;
            assign dat_we = bus_wr && !bus_addr[ADDR_W-1] && (bus_addr[GRP_W-1:0] == GRP_W'(GRP));
            assign cfg_we = bus_wr &&  bus_addr[ADDR_W-1] && (bus_addr[GRP_W-1:0] == GRP_W'(GRP));
            gpb_pin #(.PIN(p)) u_pin (
                .clk        (clk),
                .rst_n      (rst_n),
                .dat_we     (dat_we),
                .dat_bit    (bus_wdata[REL]),
                .cfg_we     (cfg_we),
                .cfg_nib    (bus_wdata[REL*MODE_W +: MODE_W]),
                .sync_lvl   (lvl_s[p]),
                .periph_bit (periph_out[p]),
                .pad_out    (pad_out[p]),
                .pad_oe     (pad_oe[p]),
                .rd_bit     (rd_v[p]),
                .mode_q     (mode_v[p]),
                .rej        (rej_v[p])
            );
        end
    endgenerate

    // Assemble the addressed group's data bits or mode nibbles
    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NPIN; p++) begin
            if (bus_addr[GRP_W-1:0] == GRP_W'(grp_of(p))) begin
                if (bus_addr[ADDR_W-1]) bus_rdata[rel_of(p)*MODE_W +: MODE_W] = mode_v[p];
                else                    bus_rdata[rel_of(p)] = rd_v[p];
            end
        end
    end

    // Sticky record of any rejected nibble
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_q | (|rej_v);
    end

    assign cfg_err = err_q;

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);
    // R7
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rej_v) |=> cfg_err);
    // R10
    uin_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_v[4] == MD_UIN) |-> !pad_oe[4]);
endmodule

// File: tb/sim_nibble_gpio_bank.sv
module sim_nibble_gpio_bank;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pad_in = '0;
    logic [15:0] periph_out = '0;
    logic [15:0] pad_out;
    logic [15:0] pad_oe;
    logic        cfg_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [3:0] e_mode [16];
    logic       e_lat  [16];
    logic       e_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    nibble_gpio_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .periph_out(periph_out), .pad_out(pad_out), .pad_oe(pad_oe), .cfg_err(cfg_err)
    );

    function automatic int f_grp(input int p);
        return (p < 2) ? 0 : (p < 6) ? 1 : (p < 10) ? 2 : 3;
    endfunction
    function automatic int f_base(input int g);
        return (g == 0) ? 0 : (g == 1) ? 2 : (g == 2) ? 6 : 10;
    endfunction
    function automatic bit f_legal(input int p, input logic [3:0] m);
        if (m == 4'h0 || m == 4'h8) return 1;
        if (m == 4'h2) return (p == 4 || p == 5);
        if (m == 4'h9) return p <= 3;
        if (m == 4'hA) return p <= 1;
        return 0;
    endfunction
    function automatic bit f_oe(input int p);
        return e_mode[p] == 4'h8 || e_mode[p] == 4'h9 || e_mode[p] == 4'hA;
    endfunction
    function automatic logic [15:0] f_oe_vec();
        logic [15:0] v = '0;
        for (int p = 0; p < 16; p++) v[p] = f_oe(p);
        return v;
    endfunction
    function automatic logic [15:0] f_out_vec();
        logic [15:0] v = '0;
        for (int p = 0; p < 16; p++)
            v[p] = (e_mode[p] == 4'h9 || e_mode[p] == 4'hA) ? periph_out[p] : e_lat[p];
        return v;
    endfunction
    function automatic logic [31:0] f_word(input int a);
        logic [31:0] w = '0;
        for (int p = 0; p < 16; p++) begin
            if (f_grp(p) == (a % 4)) begin
                int r = p - f_base(f_grp(p));
                if (a >= 4) w[r*4 +: 4] = e_mode[p];
                else        w[r] = f_oe(p) ? e_lat[p] : pad_in[p];
            end
        end
        return w;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = d;
        tick();
        bus_wr = 1'b0;
        for (int p = 0; p < 16; p++) begin
            if (f_grp(p) == (a % 4)) begin
                int r = p - f_base(f_grp(p));
                if (a < 4) e_lat[p] = d[r];
                else if (f_legal(p, d[r*4 +: 4])) e_mode[p] = d[r*4 +: 4];
                else e_err = 1'b1;
            end
        end
    endtask

    task automatic rd_chk(input string req, input int a);
        bus_addr = 3'(a);
        #1;
        chk(req, bus_rdata, f_word(a));
    endtask

    task automatic all_chk(input string req);
        for (int a = 0; a < 8; a++) rd_chk(req, a);
        chk(req, {16'h0, pad_oe}, {16'h0, f_oe_vec()});
        chk(req, {16'h0, pad_out}, {16'h0, f_out_vec()});
        chk(req, {31'h0, cfg_err}, {31'h0, e_err});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int p = 0; p < 16; p++) begin e_mode[p] = 4'h0; e_lat[p] = 1'b0; end
        e_err = 1'b0;
        @(negedge clk);
        tick(); tick(); tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        all_chk("R1");

        // R2 group mapping of data bits; R4 output drive
        wr(6, 32'h8888_8888);
        wr(2, 32'hFFFF_FFF5);
        all_chk("R2");
        chk("R4", {16'h0, pad_oe & 16'h03C0}, 32'h03C0);
        chk("R4", {16'h0, pad_out & 16'h03C0}, 32'h0140);

        // R9 two-edge synchronizer latency on pin 0 (input mode)
        pad_in[0] = 1'b1;
        tick();
        bus_addr = 3'd0; #1;
        chk("R9", {31'h0, bus_rdata[0]}, 32'h0);
        tick();
        bus_addr = 3'd0; #1;
        chk("R9", {31'h0, bus_rdata[0]}, 32'h1);
        tick();

        // R5 legal alternate codes on their pins; R3 readback
        wr(5, 32'h0000_2299);
        wr(4, 32'h0000_009A);
        all_chk("R5");
        chk("R3", f_word(5), 32'h0000_2299);

        // R10 alternate drive from periph_out, 0x2 not driving
        periph_out = 16'h000A;
        #1;
        all_chk("R10");
        chk("R10", {16'h0, pad_oe & 16'h003F}, 32'h000F);

        // R6 illegal nibble on pin 0 while pin 1 takes 0x8; R7 flag
        chk("R7", {31'h0, cfg_err}, 32'h0);
        wr(4, 32'h0000_0082);
        chk("R6", f_word(4), 32'h0000_008A);
        all_chk("R6");
        chk("R7", {31'h0, cfg_err}, 32'h1);
        wr(4, 32'h0000_0000);
        chk("R7", {31'h0, cfg_err}, 32'h1);

        // R8 readback select under random traffic
        for (int it = 0; it < 400; it++) begin
            int op = int'($urandom % 4);
            if (op == 0) begin
                pad_in = 16'($urandom);
                periph_out = 16'($urandom);
                tick(); tick(); tick();
            end else if (op == 1) begin
                wr(int'($urandom % 4), $urandom);
            end else begin
                logic [31:0] d = '0;
                for (int n = 0; n < 6; n++) begin
                    int k = int'($urandom % 8);
                    d[n*4 +: 4] = (k < 2) ? 4'h0 : (k < 4) ? 4'h8 : (k == 4) ? 4'h9 :
                                  (k == 5) ? 4'hA : (k == 6) ? 4'h2 : 4'($urandom);
                end
                wr(4 + int'($urandom % 4), d);
            end
            all_chk("R8");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule